// File: doc/BRIEF.md
# Programmable Ethernet Test Frame Generator

This block produces a paced burst of raw Ethernet frames for network load and latency tests. Software programs the frame length, the number of frames, the start-to-start spacing and the destination MAC address through a small write-only register port, then writes a start bit. The generator sends the frames over a byte-wide valid/ready/last stream toward a MAC transmit path. Each frame carries a header made of the destination address, a fixed source address and a fixed EtherType, followed by a sequence number and a counting payload. FCS generation is left to the MAC.

Each run's settings are captured when the run starts, so software may prepare the next run while the current one is still going. Frames shorter than the Ethernet minimum are padded. When the spacing is at its minimum, frames leave back to back at one byte per clock. A busy output covers the whole run, up to the acceptance of the final byte.

Top module: `eth_test_frame_gen`

## Requirements
- R1: Bytes 0 to 5 of every frame are the destination address, most significant byte first. Bytes 6 to 11 are the SRC_MAC parameter, most significant byte first. Bytes 12 and 13 are the ETYPE parameter, high byte first.
- R2: Bytes 14 to 17 carry a 32-bit frame sequence number, most significant byte first. The number is 0 for the first frame of each run and increases by 1 for each later frame.
- R3: Every byte at index 18 or above equals the low 8 bits of its own byte index within the frame.
- R4: A frame holds max(L, 60) bytes, where L is the programmed length. tx_last is high on the final byte only.
- R5: A run sends exactly the programmed number of frames and then stops. A start with a frame count of 0 sends nothing and leaves busy low.
- R6: With tx_ready held high, the first bytes of consecutive frames appear max(G, frame bytes) cycles apart, where G is the programmed gap. A gap of 0 up to the frame length gives back-to-back frames with tx_valid staying high.
- R7: While tx_valid is high and tx_ready is low, tx_data and tx_last hold their values and no byte is lost or repeated.
- R8: After reset, busy, tx_valid and tx_last are low. busy rises in the cycle after the start write. It falls in the cycle after the final byte of the last frame is accepted, and tx_valid is low then. tx_valid is never high in the cycle after a cycle with busy low.
- R9: Length, count, gap and address are captured at start. Register writes and start writes made during a run have no effect on that run.
- R10: Register map, all writes: address 0 bit 0 = start; address 1 bits 10:0 = frame length; address 2 bits 15:0 = frame count; address 3 bits 15:0 = gap in cycles; address 4 = destination address bits 31:0; address 5 bits 15:0 = destination address bits 47:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Run in progress |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The case that matters most is the acceptance of a frame's final byte in the same cycle that the spacing counter allows the next frame to start. The next first byte must then be loaded in that cycle and must not slip by one. The bench sets up this case by sweeping the gap below, equal to and above the padded frame length with tx_ready held high. It checks that the measured start-to-start distance equals the larger of the two values. The same sweep runs again with tx_ready toggled pseudo-randomly. This places stalls on the frame boundary, where every accepted byte is compared with its computed value and the frame count is checked.

// File: rtl/efg_pkg.sv
package efg_pkg;
  localparam int MIN_FRAME = 60;
  localparam int HDR_BYTES = 18;
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_LEN  = 3'd1;
  localparam logic [2:0] RA_CNT  = 3'd2;
  localparam logic [2:0] RA_GAP  = 3'd3;
  localparam logic [2:0] RA_DSTL = 3'd4;
  localparam logic [2:0] RA_DSTH = 3'd5;
  typedef enum logic {ST_IDLE, ST_RUN} run_state_e;
endpackage

// File: rtl/efg_regs.sv
module efg_regs
  import efg_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int CNT_W = 16,
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  output logic             start,
  output logic [LEN_W-1:0] len_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [GAP_W-1:0] gap_q,
  output logic [47:0]      dst_q
);
  assign start = wr && (addr == RA_CTRL) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      cnt_q <= '0;
      gap_q <= '0;
      dst_q <= '0;
    end else if (wr) begin
      case (addr)
        RA_LEN:  len_q <= wdata[LEN_W-1:0];
        RA_CNT:  cnt_q <= wdata[CNT_W-1:0];
        RA_GAP:  gap_q <= wdata[GAP_W-1:0];
        RA_DSTL: dst_q[31:0] <= wdata;
        RA_DSTH: dst_q[47:32] <= wdata[15:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/efg_byte.sv
module efg_byte
  import efg_pkg::*;
#(
  parameter int          LEN_W   = 11,
  parameter logic [47:0] SRC_MAC = 48'h02_1A_2B_3C_4D_5E,
  parameter logic [15:0] ETYPE   = 16'h88B5
) (
  input  logic [LEN_W-1:0] idx,
  input  logic [47:0]      dst,
  input  logic [31:0]      seq,
  output logic [7:0]       byte_o
);
  int i;

  always_comb begin
    i = int'(idx);
    if (i < 6)
      byte_o = 8'(dst >> (8 * (5 - i)));
    else if (i < 12)
      byte_o = 8'(SRC_MAC >> (8 * (11 - i)));
    else if (i == 12)
      byte_o = ETYPE[15:8];
    else if (i == 13)
      byte_o = ETYPE[7:0];
    else if (i < HDR_BYTES)
      byte_o = 8'(seq >> (8 * (17 - i)));
    else
      byte_o = idx[7:0];
  end
endmodule

// File: rtl/efg_ctrl.sv
module efg_ctrl
  import efg_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int CNT_W = 16,
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic [47:0]      cfg_dst,
  input  logic             tx_ready,
  input  logic [7:0]       byte_in,
  output logic [LEN_W-1:0] idx,
  output logic [31:0]      seq,
  output logic [47:0]      run_dst,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  output logic             tx_last,
  output logic             busy
);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  run_state_e       state;
  logic [LEN_W-1:0] run_len;
  logic [CNT_W-1:0] frames_left;
  logic [GAP_W-1:0] run_gap;
  logic [GAP_W-1:0] gap_cnt;
  logic             first;
  logic [LEN_W-1:0] len_eff;
  logic             out_free;
  logic             gap_ok;
  logic             is_last;
  logic             load;

  assign len_eff  = (cfg_len < MIN_LEN) ? MIN_LEN : cfg_len;
  assign out_free = !tx_valid || tx_ready;
  assign gap_ok   = ({1'b0, gap_cnt} + 1'b1) >= {1'b0, run_gap};
  assign is_last  = (idx == run_len - 1'b1);
  assign load     = (state == ST_RUN) && out_free && ((idx != '0) || first || gap_ok);
  assign busy     = (state == ST_RUN) || tx_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      run_len     <= MIN_LEN;
      frames_left <= '0;
      run_gap     <= '0;
      run_dst     <= '0;
      gap_cnt     <= '0;
      first       <= 1'b0;
      idx         <= '0;
      seq         <= '0;
      tx_data     <= '0;
      tx_valid    <= 1'b0;
      tx_last     <= 1'b0;
    end else begin
      if (load && (idx == '0))
        gap_cnt <= '0;
      else if (gap_cnt != GAP_MAX)
        gap_cnt <= gap_cnt + 1'b1;

      if (!busy && start && (cfg_cnt != '0)) begin
        state       <= ST_RUN;
        run_len     <= len_eff;
        frames_left <= cfg_cnt;
        run_gap     <= cfg_gap;
        run_dst     <= cfg_dst;
        first       <= 1'b1;
        idx         <= '0;
        seq         <= '0;
      end

      if (load) begin
        tx_data  <= byte_in;
        tx_valid <= 1'b1;
        tx_last  <= is_last;
        if (is_last) begin
          idx   <= '0;
          first <= 1'b0;
          if (frames_left == CNT_W'(1)) begin
            state <= ST_IDLE;
          end else begin
            frames_left <= frames_left - 1'b1;
            seq         <= seq + 1'b1;
          end
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
        tx_last  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eth_test_frame_gen.sv
module eth_test_frame_gen
  import efg_pkg::*;
#(
  parameter int          LEN_W   = 11,
  parameter int          CNT_W   = 16,
  parameter int          GAP_W   = 16,
  parameter logic [47:0] SRC_MAC = 48'h02_1A_2B_3C_4D_5E,
  parameter logic [15:0] ETYPE   = 16'h88B5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic        busy,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  input  logic        tx_ready
);
  logic             start;
  logic [LEN_W-1:0] cfg_len;
  logic [CNT_W-1:0] cfg_cnt;
  logic [GAP_W-1:0] cfg_gap;
  logic [47:0]      cfg_dst;
  logic [LEN_W-1:0] idx;
  logic [31:0]      seq;
  logic [47:0]      run_dst;
  logic [7:0]       next_byte;

  efg_regs #(.LEN_W(LEN_W), .CNT_W(CNT_W), .GAP_W(GAP_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .start(start), .len_q(cfg_len), .cnt_q(cfg_cnt), .gap_q(cfg_gap), .dst_q(cfg_dst)
  );

  efg_byte #(.LEN_W(LEN_W), .SRC_MAC(SRC_MAC), .ETYPE(ETYPE)) u_byte (
    .idx(idx), .dst(run_dst), .seq(seq), .byte_o(next_byte)
  );

  efg_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W), .GAP_W(GAP_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .cfg_len(cfg_len), .cfg_cnt(cfg_cnt),
    .cfg_gap(cfg_gap), .cfg_dst(cfg_dst), .tx_ready(tx_ready), .byte_in(next_byte),
    .idx(idx), .seq(seq), .run_dst(run_dst), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .busy(busy)
  );
endmodule

// File: rtl/eth_test_frame_gen_chk.sv
module eth_test_frame_gen_chk #(
  parameter int LEN_W = 11
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_last,
  input logic       tx_ready
);
  logic [LEN_W:0] acc_cnt;

  always_ff @(posedge clk) begin
    if (rst) acc_cnt <= '0;
    else if (tx_valid && tx_ready) acc_cnt <= tx_last ? '0 : acc_cnt + 1'b1;
  end

  // R7
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R4
  a_r4_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  // R4
  a_r4_min_frame: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_last) |-> (acc_cnt >= (LEN_W+1)'(59)));

  // R8
  a_r8_valid_in_run: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);

  // R8
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !tx_valid);
endmodule

bind eth_test_frame_gen eth_test_frame_gen_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_last(tx_last), .tx_ready(tx_ready)
);

// File: tb/sim_eth_test_frame_gen.sv
module sim_eth_test_frame_gen;
  localparam logic [47:0] SRC   = 48'h02_1A_2B_3C_4D_5E;
  localparam logic [15:0] ETYPE = 16'h88B5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        busy;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_last;
  logic        tx_ready = 1'b1;

  always #4 clk = ~clk;

  eth_test_frame_gen #(.SRC_MAC(SRC), .ETYPE(ETYPE)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(busy), .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  int nchk = 0;
  int nerr = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          e_len, e_cnt, e_gap;
  logic [47:0] e_dst;
  bit          rdy_rand = 0;
  logic [15:0] lfsr = 16'hACE1;

  bit     mon_on = 0;
  int     m_frame, m_idx;
  bit     seen_start, idle_chk, stalled;
  longint prev_start;
  logic [7:0] stall_data;
  logic       stall_last;

  task automatic check(bit ok, string req, longint act, longint exp, string what);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] exp_byte(int i, int f);
    if (i < 6)  return 8'(e_dst >> (8 * (5 - i)));
    if (i < 12) return 8'(SRC >> (8 * (11 - i)));
    if (i == 12) return ETYPE[15:8];
    if (i == 13) return ETYPE[7:0];
    if (i < 18) return 8'(32'(f) >> (8 * (17 - i)));
    return 8'(i);
  endfunction

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  always @(negedge clk) begin
    if (mon_on) begin
      int leff;
      leff = (e_len < 60) ? 60 : e_len;
      if (idle_chk) begin
        idle_chk = 0;
        check(!busy && !tx_valid, "R8", {busy, tx_valid}, 0, "busy/valid after final byte");
      end
      if (stalled) begin
        stalled = 0;
        check(tx_valid && tx_data == stall_data && tx_last == stall_last, "R7",
              tx_data, stall_data, "byte held during stall");
      end
      if (tx_valid && !seen_start && m_idx == 0) begin
        seen_start = 1;
        if (m_frame > 0 && !rdy_rand)
          check(cyc - prev_start == longint'((e_gap > leff) ? e_gap : leff), "R6",
                cyc - prev_start, (e_gap > leff) ? e_gap : leff, "start spacing");
        prev_start = cyc;
      end
      if (tx_valid && !tx_ready) begin
        stalled = 1;
        stall_data = tx_data;
        stall_last = tx_last;
      end
      if (tx_valid && tx_ready) begin
        if (m_frame >= e_cnt) begin
          check(0, "R5", m_frame + 1, e_cnt, "extra frame byte");
        end else begin
          logic [7:0] eb;
          eb = exp_byte(m_idx, m_frame);
          if (m_idx < 14)      check(tx_data == eb, "R1", tx_data, eb, "header byte");
          else if (m_idx < 18) check(tx_data == eb, "R2", tx_data, eb, "sequence byte");
          else                 check(tx_data == eb, "R3", tx_data, eb, "payload byte");
          check(tx_last == (m_idx == leff - 1), "R4", tx_last, m_idx == leff - 1, "last flag");
          if (tx_last || m_idx >= leff - 1) begin
            m_frame++;
            m_idx = 0;
            seen_start = 0;
            if (m_frame == e_cnt) idle_chk = 1;
          end else begin
            m_idx++;
          end
        end
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic run_cfg(int len, int cnt, int gap, bit rnd);
    e_len = len; e_cnt = cnt; e_gap = gap;
    e_dst = {16'hA5C3, 16'(len), 16'(gap * 7 + cnt)};
    wr(3'd1, 32'(len));
    wr(3'd2, 32'(cnt));
    wr(3'd3, 32'(gap));
    wr(3'd4, e_dst[31:0]);
    wr(3'd5, {16'h0, e_dst[47:32]});
    rdy_rand = rnd;
    m_frame = 0; m_idx = 0; seen_start = 0; idle_chk = 0; stalled = 0; prev_start = 0;
    mon_on = 1;
    wr(3'd0, 32'h1);
    check(busy == 1'b1, "R8", busy, 1, "busy after start write");
    // R9: writes during the run
    wr(3'd4, 32'hDEAD_BEEF);
    wr(3'd1, 32'd200);
    wr(3'd0, 32'h1);
    for (int k = 0; k < 20000 && busy; k++) @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(m_frame == cnt, "R5", m_frame, cnt, "frames in run");
    check(m_frame == cnt && m_idx == 0, "R9", m_idx, 0, "run unaffected by mid-run writes");
    mon_on = 0;
    rdy_rand = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!busy && !tx_valid && !tx_last, "R8", {busy, tx_valid, tx_last}, 0, "reset state");
    // R10 map and R5 zero count
    wr(3'd1, 32'd64);
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(!busy && !tx_valid, "R5", {busy, tx_valid}, 0, "zero count start");
    end
    foreach (int_list[li]) ;
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 2; c++)
        for (int g = 0; g < 3; g++)
          for (int l = 0; l < 4; l++) begin
            int lens[4];
            int gaps[3];
            lens = '{10, 60, 61, 75};
            gaps = '{0, 60, 90};
            run_cfg(lens[l], (c == 0) ? 1 : 3, gaps[g], r[0]);
          end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  int int_list[1];

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule